// File: doc/BRIEF.md
# Paged Flash Address Translator

This block sits between a 16-bit CPU address bus and a 128 KB flash array that is organised as eight 16 KB pages. For each CPU address it decides whether the access goes to the low RAM/register area or to flash. For a flash access it forms a 17-bit physical address by placing a 3-bit page number above the 14 low address bits. The top quarter and the second quarter of the CPU space always show fixed pages. The third quarter is a movable window, and a software-written page register chooses which page appears there. Just below the second quarter, a tail of page 0 also shows up in linear space, above the RAM and registers.

Software reads and writes the page register at one direct-page address. The whole decode is combinational from the address and the registered page value. A parameter builds a six-page variant. In that variant a window access to a page that does not exist is flagged, and the access returns all ones.

Top module: `paged_flash_xlat`

## Requirements
- R1: After reset the page register holds 2, and a read at CPU address 0x0078 returns 0x02 on `cpu_rdata`.
- R2: A cycle with `wr_en` high and `cpu_addr` = 0x0078 loads `wr_data[2:0]` into the page register at that clock edge, so the next cycle uses the new value. Bits 7:3 of `wr_data` are dropped, and a read returns them as zero.
- R3: A write strobe at any address other than 0x0078 leaves the page register unchanged.
- R4: Addresses 0x0000–0x20EF select region code 3'b001 (RAM/registers), and `flash_addr` is 0 for them.
- R5: Addresses 0x20F0–0x3FFF select region code 3'b010 (flash) at physical page 0, so `flash_addr` = `cpu_addr` & 0x3FFF.
- R6: Addresses 0x4000–0x7FFF select flash at physical page 1, whatever the page register holds, so `flash_addr` = 0x04000 + (`cpu_addr` − 0x4000).
- R7: Addresses 0x8000–0xBFFF select flash at the page held in the page register, so `flash_addr` = page × 0x4000 + (`cpu_addr` − 0x8000).
- R8: Addresses 0xC000–0xFFFF select flash at physical page 3, whatever the page register holds. This range includes the vectors and the option bytes at 0xFFBD–0xFFBF. Here `flash_addr` = 0x0C000 + (`cpu_addr` − 0xC000).
- R9: `region` is always one-hot: bit 0 is RAM/registers, bit 1 is flash, and bit 2 is no target.
- R10: When NUM_PAGES = 6, a window access (0x8000–0xBFFF) with page 6 or 7 raises `page_oor` and gives region 3'b100, `flash_addr` 0 and `cpu_rdata` 0xFF. Pages 0..5 translate as in R7. With NUM_PAGES = 8, `page_oor` never rises.
- R11: For a flash access `cpu_rdata` passes `flash_rdata`. At 0x0078 it returns the page register, zero-extended. At any other RAM/register address it returns 0x00.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| wr_en | input | 1 | Register-bus write strobe |
| wr_data | input | 8 | Register-bus write data |
| flash_rdata | input | 8 | Byte returned by the flash array |
| region | output | 3 | One-hot region select (bit0 RAM/reg, bit1 flash, bit2 none) |
| flash_addr | output | 17 | Physical flash byte address |
| page_oor | output | 1 | Window access to an unpopulated page |
| cpu_rdata | output | 8 | Read data toward the CPU |

## Verification
The bench probes the edges of each region: 0x20EF/0x20F0, 0x3FFF/0x4000, 0x7FFF/0x8000 and 0xBFFF/0xC000. An off-by-one in the tail bound would hand a RAM address to flash, or lose the first tail byte. It then sweeps every page value through the window and also reads both fixed windows while the page register holds other values. A decoder that let the page register leak into a fixed window would move the vectors or page 1 with it. Writes carrying upper-bit garbage and writes to a neighbouring address catch a register that keeps wide values or decodes its address loosely. A second instance built as the six-page variant must refuse pages 6 and 7 with all-ones data, while the full instance maps them normally.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   localparam int unsigned RGN_W = 3;
   // one-hot region codes: bit0 RAM/reg, bit1 flash, bit2 no target
   typedef enum logic [RGN_W-1:0] {
      RGN_REGRAM = 3'b001,
      RGN_FLASH  = 3'b010,
      RGN_NONE   = 3'b100
   } region_e;
endpackage

// File: rtl/pfx_page_reg.sv
module pfx_page_reg #(
   parameter int unsigned PAGE_W     = 3,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_RESET = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PAGE_W-1:0] page
);
   initial assert (PAGE_W <= DATA_W) else $fatal(1, "page field wider than data bus");
   initial assert (PAGE_RESET < (1 << PAGE_W)) else $fatal(1, "reset page does not fit");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      page <= PAGE_W'(PAGE_RESET);
      else if (wr_hit) page <= wr_data[PAGE_W-1:0];
   end

   // R2: a decoded write loads the low field on the following cycle
   p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> page == $past(wr_data[PAGE_W-1:0]));
   // R3: without a decoded write the page holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(page));
endmodule

// File: rtl/pfx_decode.sv
module pfx_decode
   import pfx_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned PAGE_W        = 3,
   parameter int unsigned OFS_W         = 14,
   parameter int unsigned NUM_PAGES     = 8,
   parameter int unsigned TAIL_PAGE     = 0,
   parameter int unsigned FIX_LO_PAGE   = 1,
   parameter int unsigned FIX_HI_PAGE   = 3,
   parameter int unsigned TAIL_START    = 16'h20F0,
   parameter int unsigned PAGE_REG_ADDR = 16'h0078,
   localparam int unsigned PHYS_W       = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PAGE_W-1:0] page,
   output logic [RGN_W-1:0]  region,
   output logic [PHYS_W-1:0] flash_addr,
   output logic              oor,
   output logic              page_hit
);
   localparam int unsigned FULL_PAGES = 1 << PAGE_W;

   initial assert (ADDR_W == OFS_W + 2) else $fatal(1, "address must split into four quarters");
   initial assert (NUM_PAGES <= FULL_PAGES && NUM_PAGES > FIX_HI_PAGE)
      else $fatal(1, "page count inconsistent");
   initial assert (FIX_LO_PAGE < NUM_PAGES && TAIL_PAGE < NUM_PAGES)
      else $fatal(1, "fixed page missing");
   initial assert (TAIL_START < (1 << OFS_W) && PAGE_REG_ADDR < TAIL_START)
      else $fatal(1, "low region layout invalid");

   logic             page_ok;
   logic [OFS_W-1:0] ofs;
   logic [1:0]       quarter;

   assign ofs      = addr[OFS_W-1:0];
   assign quarter  = addr[ADDR_W-1 -: 2];
   assign page_hit = (addr == ADDR_W'(PAGE_REG_ADDR));

   generate
      if (NUM_PAGES == FULL_PAGES) begin : g_full
         assign page_ok = 1'b1;
      end else begin : g_partial
         assign page_ok = ({1'b0, page} < (PAGE_W+1)'(NUM_PAGES));
      end
   endgenerate

   always_comb begin
      region     = RGN_NONE;
      flash_addr = '0;
      oor        = 1'b0;
      case (quarter)
         2'b00: begin
            if (addr < ADDR_W'(TAIL_START)) begin
               region = RGN_REGRAM;
            end else begin
               region     = RGN_FLASH;
               flash_addr = {PAGE_W'(TAIL_PAGE), ofs};
            end
         end
         2'b01: begin
            region     = RGN_FLASH;
            flash_addr = {PAGE_W'(FIX_LO_PAGE), ofs};
         end
         2'b10: begin
            if (page_ok) begin
               region     = RGN_FLASH;
               flash_addr = {page, ofs};
            end else begin
               oor = 1'b1;
            end
         end
         default: begin
            region     = RGN_FLASH;
            flash_addr = {PAGE_W'(FIX_HI_PAGE), ofs};
         end
      endcase
   end

   // R9: exactly one region is selected
   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(region) == 1);
   // R8: top quarter ignores the page register
   p_hi_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (quarter == 2'b11) |-> flash_addr[PHYS_W-1 -: PAGE_W] == PAGE_W'(FIX_HI_PAGE));
   // R6: second quarter ignores the page register
   p_lo_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (quarter == 2'b01) |-> flash_addr[PHYS_W-1 -: PAGE_W] == PAGE_W'(FIX_LO_PAGE));
   // R10: an unpopulated page selects nothing
   p_oor_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oor |-> (region == RGN_NONE && flash_addr == '0 && quarter == 2'b10));
   // R4: RAM/register accesses carry no flash address
   p_regram_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RGN_REGRAM) |-> (flash_addr == '0 && quarter == 2'b00));
endmodule

// File: rtl/pfx_rdmux.sv
module pfx_rdmux
   import pfx_pkg::*;
#(
   parameter int unsigned PAGE_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RGN_W-1:0]  region,
   input  logic              oor,
   input  logic              page_hit,
   input  logic [PAGE_W-1:0] page,
   input  logic [DATA_W-1:0] flash_rdata,
   output logic [DATA_W-1:0] cpu_rdata
);
   always_comb begin
      if (oor)                      cpu_rdata = '1;
      else if (page_hit)            cpu_rdata = DATA_W'(page);
      else if (region == RGN_FLASH) cpu_rdata = flash_rdata;
      else                          cpu_rdata = '0;
   end

   // R10: an unpopulated page reads as all ones
   p_oor_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oor |-> cpu_rdata == '1);
   // R11: flash reads pass through untouched
   p_flash_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RGN_FLASH) |-> cpu_rdata == flash_rdata);
endmodule

// File: rtl/paged_flash_xlat.sv
module paged_flash_xlat
   import pfx_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned PAGE_W        = 3,
   parameter int unsigned OFS_W         = 14,
   parameter int unsigned NUM_PAGES     = 8,
   parameter int unsigned PAGE_RESET    = 2,
   parameter int unsigned PAGE_REG_ADDR = 16'h0078,
   parameter int unsigned TAIL_START    = 16'h20F0,
   localparam int unsigned PHYS_W       = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] flash_rdata,
   output logic [2:0]        region,
   output logic [PHYS_W-1:0] flash_addr,
   output logic              page_oor,
   output logic [DATA_W-1:0] cpu_rdata
);
   logic [PAGE_W-1:0] page;
   logic              page_hit;

   pfx_page_reg #(
      .PAGE_W(PAGE_W), .DATA_W(DATA_W), .PAGE_RESET(PAGE_RESET)
   ) u_page (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_en & page_hit),
      .wr_data(wr_data), .page(page)
   );

   pfx_decode #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .NUM_PAGES(NUM_PAGES),
      .TAIL_PAGE(0), .FIX_LO_PAGE(1), .FIX_HI_PAGE(3),
      .TAIL_START(TAIL_START), .PAGE_REG_ADDR(PAGE_REG_ADDR)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .page(page),
      .region(region), .flash_addr(flash_addr), .oor(page_oor),
      .page_hit(page_hit)
   );

   pfx_rdmux #(
      .PAGE_W(PAGE_W), .DATA_W(DATA_W)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .region(region), .oor(page_oor),
      .page_hit(page_hit), .page(page), .flash_rdata(flash_rdata),
      .cpu_rdata(cpu_rdata)
   );

   // R7: window address tracks the page register
   p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[ADDR_W-1 -: 2] == 2'b10 && !page_oor)
      |-> flash_addr == {page, cpu_addr[OFS_W-1:0]});
endmodule

// File: tb/tb_paged_flash_xlat.sv
module tb_paged_flash_xlat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  flash_rdata = 8'h5A;
   logic [2:0]  region, region6;
   logic [16:0] flash_addr, flash_addr6;
   logic        page_oor, page_oor6;
   logic [7:0]  cpu_rdata, cpu_rdata6;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   paged_flash_xlat dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_en(wr_en),
      .wr_data(wr_data), .flash_rdata(flash_rdata), .region(region),
      .flash_addr(flash_addr), .page_oor(page_oor), .cpu_rdata(cpu_rdata)
   );

   paged_flash_xlat #(.NUM_PAGES(6)) dut6 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_en(wr_en),
      .wr_data(wr_data), .flash_rdata(flash_rdata), .region(region6),
      .flash_addr(flash_addr6), .page_oor(page_oor6), .cpu_rdata(cpu_rdata6)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic put_addr(logic [15:0] a);
      @(negedge clk);
      cpu_addr = a;
      #2;
   endtask

   task automatic write_page(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      #2;
   endtask

   task automatic t_reset_r1;
      put_addr(16'h0078);
      chk("R1", "reset page read", cpu_rdata, 8'h02);
      chk("R11", "page reg region", region, 3'b001);
   endtask

   task automatic t_write_r2;
      write_page(16'h0078, 8'hF5);
      put_addr(16'h0078);
      chk("R2", "upper bits dropped", cpu_rdata, 8'h05);
      write_page(16'h0078, 8'h01);
      put_addr(16'h0078);
      chk("R2", "write page 1", cpu_rdata, 8'h01);
   endtask

   task automatic t_ignore_r3;
      write_page(16'h0079, 8'h06);
      write_page(16'h8078, 8'h07);
      put_addr(16'h0078);
      chk("R3", "stray writes ignored", cpu_rdata, 8'h01);
   endtask

   task automatic t_low_r4;
      put_addr(16'h0000);
      chk("R4", "region @0000", region, 3'b001);
      chk("R11", "ram read zero", cpu_rdata, 8'h00);
      put_addr(16'h20EF);
      chk("R4", "region @20EF", region, 3'b001);
      chk("R4", "no flash addr @20EF", flash_addr, 17'h0);
   endtask

   task automatic t_tail_r5;
      put_addr(16'h20F0);
      chk("R5", "region @20F0", region, 3'b010);
      chk("R5", "phys @20F0", flash_addr, 17'h020F0);
      put_addr(16'h3FFF);
      chk("R5", "phys @3FFF", flash_addr, 17'h03FFF);
   endtask

   task automatic t_fixed_r6_r8;
      for (int p = 0; p < 8; p += 5) begin
         write_page(16'h0078, 8'(p));
         put_addr(16'h4000);
         chk("R6", "phys @4000", flash_addr, 17'h04000);
         put_addr(16'h7FFF);
         chk("R6", "phys @7FFF", flash_addr, 17'h07FFF);
         put_addr(16'hC000);
         chk("R8", "phys @C000", flash_addr, 17'h0C000);
         put_addr(16'hFFBF);
         chk("R8", "option byte", flash_addr, 17'h0FFBF);
         put_addr(16'hFFFE);
         chk("R8", "vector", flash_addr, 17'h0FFFE);
         chk("R9", "region flash", region, 3'b010);
      end
   endtask

   task automatic t_window_r7;
      for (int p = 0; p < 8; p++) begin
         write_page(16'h0078, 8'(p));
         put_addr(16'h8000);
         chk("R7", "window base", flash_addr, 32'(p) * 32'h4000);
         put_addr(16'hBFFF);
         chk("R7", "window top", flash_addr, 32'(p) * 32'h4000 + 32'h3FFF);
         chk("R10", "full part no oor", page_oor, 1'b0);
         flash_rdata = 8'(8'h30 + p);
         put_addr(16'h9234);
         chk("R7", "window mid", flash_addr, 32'(p) * 32'h4000 + 32'h1234);
         chk("R11", "flash data", cpu_rdata, 32'(8'h30 + p));
      end
   endtask

   task automatic t_six_r10;
      for (int p = 4; p < 8; p++) begin
         write_page(16'h0078, 8'(p));
         put_addr(16'hA010);
         if (p < 6) begin
            chk("R10", "six-page valid oor", page_oor6, 1'b0);
            chk("R10", "six-page valid addr", flash_addr6, 32'(p) * 32'h4000 + 32'h2010);
            chk("R10", "six-page valid region", region6, 3'b010);
         end else begin
            chk("R10", "six-page oor", page_oor6, 1'b1);
            chk("R10", "six-page region", region6, 3'b100);
            chk("R10", "six-page data", cpu_rdata6, 8'hFF);
            chk("R10", "six-page addr", flash_addr6, 17'h0);
            chk("R10", "full part maps", flash_addr, 32'(p) * 32'h4000 + 32'h2010);
         end
      end
   endtask

   initial begin
      #100000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_r1();
      t_write_r2();
      t_ignore_r3();
      t_low_r4();
      t_tail_r5();
      t_fixed_r6_r8();
      t_window_r7();
      t_six_r10();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule